// File: doc/BRIEF.md
# Serial Command Decoder and Control Register File

This block is the control-port front end of a low-power radio transmitter. A host shifts commands in over a three-wire serial link made of an active-low select, a serial clock and a data line. Each command is identified by a prefix of variable length at its top. The block writes the matching control register, which the analog sections downstream read directly. Every register comes out of reset holding its own fixed default. One reserved word restores all of those defaults without a hardware reset.

The link pins are sampled with the block's own clock, so the serial clock must be several times slower than that clock. A status-read command turns the active-low interrupt pin into a serial data output. While the command runs, a snapshot of the status vector leaves the block most significant bit first. At every other time the pin shows the pending-interrupt input. A completed status read gives the event controller a one-cycle acknowledge. A data-transmit header gives a one-cycle start pulse to the modulator.

Top module: `spi_cmd_regs`

## Requirements
- R1: While `sel_ni` is low, `sdi_i` is taken on each rising edge of `sck_i`, most significant bit first. Once 16 bits have arrived, the whole word is written to one register, chosen by its top bits: 100b configuration (`cfg_o`), 1010b frequency (`freq_o`), 111b wake-up timer (`wut_o`), C0h power control (`pm_o`), C8h bit rate (`rate_o`), C2h battery monitor (`lbd_o`), C4h sleep (`sleep_o`), CAh button control (`pb_o`), D2h loop/reset mode (`pll_o`). Each register output carries the full 16-bit command image.
- R2: After `rst_ni` is asserted, the outputs hold these values: `cfg_o`=8080h, `pm_o`=C000h, `freq_o`=A7D0h, `rate_o`=C800h, `pwr_o`=B0h, `lbd_o`=C200h, `sleep_o`=C410h, `pb_o`=CA00h, `wut_o`=E000h, `pll_o`=D200h.
- R3: A first byte whose top nibble is 1011b is a complete 8-bit command. It is written to `pwr_o` as soon as its eighth bit arrives. Any later bits under the same select are ignored.
- R4: A command that is incomplete when `sel_ni` rises changes nothing. Once a command has completed, further bits under the same select change no register.
- R5: A frequency command writes only when its 12-bit value (bits 11:0) lies between 96 and 3903 inclusive. Any other value leaves `freq_o` as it was.
- R6: A wake-up command writes only when its exponent field (bits 12:8) is 23 or less. Any other value leaves `wut_o` as it was.
- R7: The word FE00h restores every register to its R2 value, and no register takes FE00h as data.
- R8: When the first byte is CCh, `status_i` is captured as that byte completes. Each following falling edge of `sck_i` puts the next captured bit on `irq_no`, most significant first. Zeros follow once the captured bits run out. Whenever no status read is in progress, `irq_no` equals the inverse of `event_i`.
- R9: When the full word CC00h completes, `stat_ack_o` pulses high for exactly one clock. Other words that begin with CCh produce no pulse.
- R10: The 8-bit command C6h gives a one-clock pulse on `tx_cmd_o`. The bytes that follow it under the same select change no register.
- R11: A word that matches no prefix, such as 5A5Ah, DE00h or C100h, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, which oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Serial select, active low; high restarts the interface |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| event_i | input | 1 | Pending-interrupt request from the event logic |
| status_i | input | STATUS_W | Status vector captured by a status read |
| irq_no | output | 1 | Active-low interrupt, or serial status data during a read |
| stat_ack_o | output | 1 | One-cycle pulse when a status read completes |
| tx_cmd_o | output | 1 | One-cycle pulse when a data-transmit header arrives |
| cfg_o | output | 16 | Configuration register |
| pm_o | output | 16 | Power control register |
| freq_o | output | 16 | Frequency register |
| rate_o | output | 16 | Bit-rate register |
| pwr_o | output | 8 | Output power register |
| lbd_o | output | 16 | Battery monitor register |
| sleep_o | output | 16 | Sleep register |
| pb_o | output | 16 | Button control register |
| wut_o | output | 16 | Wake-up timer register |
| pll_o | output | 16 | Loop/reset mode register |

## Verification
The word FE00h falls inside the wake-up prefix space, so the reset decode and the wake-up write both match it in the same decode cycle. The bench first loads non-default values, including a valid wake-up word, then sends FE00h and requires every output to show its default, with `wut_o` at E000h rather than any value tied to the new word. The status snapshot and a change of the live status vector can also overlap. The bench changes `status_i` partway through a read and requires the shifted bits to match the value captured when the CCh byte completed.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int CMD_W       = 16;
  localparam int BYTE_W      = 8;
  localparam int NREG        = 10;
  localparam int SYNC_STAGES = 2;
  localparam int CNT_W       = $clog2(CMD_W + 1);

  localparam int IDX_CFG   = 0;
  localparam int IDX_PM    = 1;
  localparam int IDX_FREQ  = 2;
  localparam int IDX_RATE  = 3;
  localparam int IDX_PWR   = 4;
  localparam int IDX_LBD   = 5;
  localparam int IDX_SLEEP = 6;
  localparam int IDX_PB    = 7;
  localparam int IDX_WUT   = 8;
  localparam int IDX_PLL   = 9;

  localparam logic [11:0] FREQ_MIN    = 12'd96;
  localparam logic [11:0] FREQ_MAX    = 12'd3903;
  localparam logic [4:0]  WUT_EXP_MAX = 5'd23;

  localparam logic [15:0] SOFT_RST_CODE = 16'hFE00;
  localparam logic [7:0]  STAT_CODE     = 8'hCC;
  localparam logic [7:0]  TX_CODE       = 8'hC6;

  typedef logic [CMD_W-1:0] word_t;

  function automatic word_t reg_default(input int idx);
    case (idx)
      IDX_CFG:   return 16'h8080;
      IDX_PM:    return 16'hC000;
      IDX_FREQ:  return 16'hA7D0;
      IDX_RATE:  return 16'hC800;
      IDX_PWR:   return 16'h00B0;
      IDX_LBD:   return 16'hC200;
      IDX_SLEEP: return 16'hC410;
      IDX_PB:    return 16'hCA00;
      IDX_WUT:   return 16'hE000;
      IDX_PLL:   return 16'hD200;
      default:   return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/spi_front.sv
module spi_front
  import spi_cmd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sel_ni,
  input  logic  sck_i,
  input  logic  sdi_i,
  input  logic  end_short_i,
  output word_t word_o,
  output logic  byte_v_o,
  output logic  word_v_o,
  output logic  fall_o,
  output logic  active_o
);
  logic [SYNC_STAGES:0]   sck_q;
  logic [SYNC_STAGES-1:0] sdi_q;
  logic [SYNC_STAGES-1:0] sel_q;
  logic                   sck_rise, sck_fall, sel_s, sdi_s;
  logic [CNT_W-1:0]       cnt;
  logic                   done;
  word_t                  sh;

  assign sck_rise = sck_q[SYNC_STAGES-1] & ~sck_q[SYNC_STAGES];
  assign sck_fall = ~sck_q[SYNC_STAGES-1] & sck_q[SYNC_STAGES];
  assign sel_s    = sel_q[SYNC_STAGES-1];
  assign sdi_s    = sdi_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      sdi_q <= '0;
      sel_q <= '1;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-1:0], sck_i};
      sdi_q <= {sdi_q[SYNC_STAGES-2:0], sdi_i};
      sel_q <= {sel_q[SYNC_STAGES-2:0], sel_ni};
    end
  end

  // a completed command (short or full) freezes the shifter until select rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      done     <= 1'b0;
      sh       <= '0;
      byte_v_o <= 1'b0;
      word_v_o <= 1'b0;
    end else begin
      byte_v_o <= 1'b0;
      word_v_o <= 1'b0;
      if (sel_s) begin
        cnt  <= '0;
        done <= 1'b0;
      end else begin
        if (end_short_i) done <= 1'b1;
        if (sck_rise && !done && !end_short_i) begin
          sh  <= {sh[CMD_W-2:0], sdi_s};
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(BYTE_W - 1)) byte_v_o <= 1'b1;
          if (cnt == CNT_W'(CMD_W - 1)) begin
            word_v_o <= 1'b1;
            done     <= 1'b1;
          end
        end
      end
    end
  end

  assign word_o   = sh;
  assign fall_o   = sck_fall & ~sel_s;
  assign active_o = ~sel_s;

  a_r4_sel_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_s |=> (cnt == '0) && !done);
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(CMD_W));
  a_r1_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_v_o && word_v_o));
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import spi_cmd_pkg::*;
(
  input  word_t            word_i,
  input  logic             byte_v_i,
  input  logic             word_v_i,
  output logic [NREG-1:0]  wr_en_o,
  output word_t            wr_data_o,
  output logic             soft_rst_o,
  output logic             end_short_o,
  output logic             stat_start_o,
  output logic             stat_ack_o,
  output logic             tx_o
);
  logic [7:0] first_b;
  assign first_b = word_i[7:0];

  always_comb begin
    wr_en_o      = '0;
    soft_rst_o   = 1'b0;
    end_short_o  = 1'b0;
    stat_start_o = 1'b0;
    stat_ack_o   = 1'b0;
    tx_o         = 1'b0;
    wr_data_o    = byte_v_i ? {8'h00, first_b} : word_i;
    if (byte_v_i) begin
      if (first_b[7:4] == 4'hB) begin
        wr_en_o[IDX_PWR] = 1'b1;
        end_short_o      = 1'b1;
      end else if (first_b == TX_CODE) begin
        tx_o        = 1'b1;
        end_short_o = 1'b1;
      end else if (first_b == STAT_CODE) begin
        stat_start_o = 1'b1;
      end
    end
    if (word_v_i) begin
      // reset code lies inside the wake-up space: test it first
      if (word_i == SOFT_RST_CODE) begin
        soft_rst_o = 1'b1;
      end else if (word_i[15:13] == 3'b100) begin
        wr_en_o[IDX_CFG] = 1'b1;
      end else if (word_i[15:12] == 4'hA) begin
        wr_en_o[IDX_FREQ] = (word_i[11:0] >= FREQ_MIN) && (word_i[11:0] <= FREQ_MAX);
      end else if (word_i[15:13] == 3'b111) begin
        wr_en_o[IDX_WUT] = (word_i[12:8] <= WUT_EXP_MAX);
      end else begin
        case (word_i[15:8])
          8'hC0:     wr_en_o[IDX_PM]    = 1'b1;
          8'hC8:     wr_en_o[IDX_RATE]  = 1'b1;
          8'hC2:     wr_en_o[IDX_LBD]   = 1'b1;
          8'hC4:     wr_en_o[IDX_SLEEP] = 1'b1;
          8'hCA:     wr_en_o[IDX_PB]    = 1'b1;
          8'hD2:     wr_en_o[IDX_PLL]   = 1'b1;
          STAT_CODE: stat_ack_o         = (word_i[7:0] == 8'h00);
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import spi_cmd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NREG-1:0]       wr_en_i,
  input  word_t                 wr_data_i,
  input  logic                  soft_rst_i,
  output word_t [NREG-1:0]      regs_o
);
  word_t q [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam word_t DEF = reg_default(gi);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q[gi] <= DEF;
      else if (soft_rst_i)    q[gi] <= DEF;
      else if (wr_en_i[gi])   q[gi] <= wr_data_i;
    end
    assign regs_o[gi] = q[gi];
  end

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && (wr_en_i == '0)) |=> $stable(regs_o));
  a_r5_freq_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o[IDX_FREQ][11:0] >= FREQ_MIN) && (regs_o[IDX_FREQ][11:0] <= FREQ_MAX));
  a_r6_wut_exp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o[IDX_WUT][12:8] <= WUT_EXP_MAX);
endmodule

// File: rtl/stat_tx.sv
module stat_tx #(
  parameter int STATUS_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                active_i,
  input  logic                start_i,
  input  logic                fall_i,
  input  logic [STATUS_W-1:0] status_i,
  input  logic                event_i,
  output logic                irq_no
);
  logic                mode;
  logic                out_bit;
  logic [STATUS_W-1:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode    <= 1'b0;
      out_bit <= 1'b0;
      sh      <= '0;
    end else if (!active_i) begin
      mode <= 1'b0;
    end else if (start_i) begin
      mode    <= 1'b1;
      out_bit <= 1'b0;
      sh      <= status_i;
    end else if (mode && fall_i) begin
      out_bit <= sh[STATUS_W-1];
      sh      <= {sh[STATUS_W-2:0], 1'b0};
    end
  end

  assign irq_no = mode ? out_bit : ~event_i;

  a_r8_start_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> mode);
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int STATUS_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_ni,
  input  logic                sck_i,
  input  logic                sdi_i,
  input  logic                event_i,
  input  logic [STATUS_W-1:0] status_i,
  output logic                irq_no,
  output logic                stat_ack_o,
  output logic                tx_cmd_o,
  output logic [15:0]         cfg_o,
  output logic [15:0]         pm_o,
  output logic [15:0]         freq_o,
  output logic [15:0]         rate_o,
  output logic [7:0]          pwr_o,
  output logic [15:0]         lbd_o,
  output logic [15:0]         sleep_o,
  output logic [15:0]         pb_o,
  output logic [15:0]         wut_o,
  output logic [15:0]         pll_o
);
  word_t             word;
  logic              byte_v, word_v, fall, active;
  logic [NREG-1:0]   wr_en;
  word_t             wr_data;
  logic              soft_rst, end_short, stat_start;
  word_t [NREG-1:0]  regs;

  spi_front u_front (
    .clk_i, .rst_ni, .sel_ni, .sck_i, .sdi_i,
    .end_short_i(end_short),
    .word_o(word), .byte_v_o(byte_v), .word_v_o(word_v),
    .fall_o(fall), .active_o(active)
  );

  cmd_decode u_dec (
    .word_i(word), .byte_v_i(byte_v), .word_v_i(word_v),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .soft_rst_o(soft_rst),
    .end_short_o(end_short), .stat_start_o(stat_start),
    .stat_ack_o(stat_ack_o), .tx_o(tx_cmd_o)
  );

  reg_bank u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_data_i(wr_data),
    .soft_rst_i(soft_rst), .regs_o(regs)
  );

  stat_tx #(.STATUS_W(STATUS_W)) u_stat (
    .clk_i, .rst_ni, .active_i(active), .start_i(stat_start),
    .fall_i(fall), .status_i, .event_i, .irq_no
  );

  assign cfg_o   = regs[IDX_CFG];
  assign pm_o    = regs[IDX_PM];
  assign freq_o  = regs[IDX_FREQ];
  assign rate_o  = regs[IDX_RATE];
  assign pwr_o   = regs[IDX_PWR][7:0];
  assign lbd_o   = regs[IDX_LBD];
  assign sleep_o = regs[IDX_SLEEP];
  assign pb_o    = regs[IDX_PB];
  assign wut_o   = regs[IDX_WUT];
  assign pll_o   = regs[IDX_PLL];

  a_r9_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_ack_o |=> !stat_ack_o);
  a_r10_tx_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cmd_o |=> !tx_cmd_o);
  a_r7_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (cfg_o == 16'h8080) && (wut_o == 16'hE000) && (freq_o == 16'hA7D0)
                 && (pwr_o == 8'hB0) && (pll_o == 16'hD200));
  a_r3_pwr_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs[IDX_PWR][15:8] == 8'h00);
  a_r8_idle_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ni && $past(sel_ni) && $past(sel_ni, 2) && $past(sel_ni, 3)) |-> (irq_no == ~event_i));
  a_r5_freq_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_v && (word[15:12] == 4'hA) && (word[11:0] > FREQ_MAX)) |=> $stable(freq_o));
endmodule

// File: tb/sim_spi_cmd_regs.sv
module sim_spi_cmd_regs;
  localparam int HP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, sck = 1'b0, sdi = 1'b0, evt = 1'b0;
  logic [15:0] status = 16'h0000;
  logic        irq_n, ack, tx;
  logic [15:0] cfg, pm, freq, rate, lbd, slp, pb, wut, pll;
  logic [7:0]  pwr;

  int nchk = 0, nfail = 0, ack_cnt = 0, tx_cnt = 0;
  bit finished = 0;
  logic [15:0] exp_r [10];

  always #5 clk = ~clk;

  spi_cmd_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .sck_i(sck), .sdi_i(sdi),
    .event_i(evt), .status_i(status), .irq_no(irq_n), .stat_ack_o(ack),
    .tx_cmd_o(tx), .cfg_o(cfg), .pm_o(pm), .freq_o(freq), .rate_o(rate),
    .pwr_o(pwr), .lbd_o(lbd), .sleep_o(slp), .pb_o(pb), .wut_o(wut), .pll_o(pll)
  );

  always @(posedge clk) begin
    if (ack) ack_cnt <= ack_cnt + 1;
    if (tx)  tx_cnt  <= tx_cnt + 1;
  end

  task automatic wait_clk(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic set_defaults();
    exp_r[0] = 16'h8080; exp_r[1] = 16'hC000; exp_r[2] = 16'hA7D0;
    exp_r[3] = 16'hC800; exp_r[4] = 16'h00B0; exp_r[5] = 16'hC200;
    exp_r[6] = 16'hC410; exp_r[7] = 16'hCA00; exp_r[8] = 16'hE000;
    exp_r[9] = 16'hD200;
  endtask

  task automatic check_regs(input string req);
    chk({req, " cfg"},   32'(cfg),   32'(exp_r[0]));
    chk({req, " pm"},    32'(pm),    32'(exp_r[1]));
    chk({req, " freq"},  32'(freq),  32'(exp_r[2]));
    chk({req, " rate"},  32'(rate),  32'(exp_r[3]));
    chk({req, " pwr"},   32'(pwr),   32'(exp_r[4][7:0]));
    chk({req, " lbd"},   32'(lbd),   32'(exp_r[5]));
    chk({req, " sleep"}, 32'(slp),   32'(exp_r[6]));
    chk({req, " pb"},    32'(pb),    32'(exp_r[7]));
    chk({req, " wut"},   32'(wut),   32'(exp_r[8]));
    chk({req, " pll"},   32'(pll),   32'(exp_r[9]));
  endtask

  // bit i of the frame lands at rx[n-1-i]; irq_n is sampled at the end of each low phase
  task automatic xfer(input logic [31:0] data, input int n, output logic [31:0] rx);
    rx = '0;
    sel_n = 1'b0;
    wait_clk(3);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0;
      sdi = data[n-1-i];
      wait_clk(HP);
      rx = {rx[30:0], irq_n};
      sck = 1'b1;
      wait_clk(HP);
    end
    sck = 1'b0;
    wait_clk(HP);
    sel_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic wr16(input logic [15:0] w);
    logic [31:0] rx;
    xfer({16'h0, w}, 16, rx);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] rx;
    int a0, t0;
    set_defaults();
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);

    // R2 reset values
    check_regs("R2");
    evt = 1'b1; wait_clk(1);
    chk("R8 idle pin evt=1", 32'(irq_n), 32'(1'b0));
    evt = 1'b0; wait_clk(1);
    chk("R8 idle pin evt=0", 32'(irq_n), 32'(1'b1));

    // R1 every 16-bit register by prefix
    wr16(16'h9123); exp_r[0] = 16'h9123;
    wr16(16'hC0F5); exp_r[1] = 16'hC0F5;
    wr16(16'hA100); exp_r[2] = 16'hA100;
    wr16(16'hC8AA); exp_r[3] = 16'hC8AA;
    wr16(16'hC2B7); exp_r[5] = 16'hC2B7;
    wr16(16'hC455); exp_r[6] = 16'hC455;
    wr16(16'hCA3C); exp_r[7] = 16'hCA3C;
    wr16(16'hE712); exp_r[8] = 16'hE712;
    wr16(16'hD2C1); exp_r[9] = 16'hD2C1;
    check_regs("R1");

    // R3 short power command, 8 and 16 bits
    xfer(32'hB5, 8, rx); exp_r[4] = 16'h00B5;
    check_regs("R3 8-bit");
    xfer(32'hB7C0, 16, rx); exp_r[4] = 16'h00B7;
    check_regs("R3 trailing byte ignored");

    // R4 partial and trailing bits
    xfer(32'hC0A, 12, rx);
    check_regs("R4 partial");
    xfer(32'hC01234, 24, rx); exp_r[1] = 16'hC012;
    check_regs("R4 trailing");

    // R10 transmit header
    t0 = tx_cnt;
    xfer(32'hC68080, 24, rx);
    chk("R10 tx pulse count", 32'(tx_cnt - t0), 32'd1);
    check_regs("R10 data bytes ignored");

    // R11 unknown codes
    wr16(16'h5A5A); wr16(16'hDE00); wr16(16'hC100); wr16(16'h0000);
    check_regs("R11");

    // R8/R9 status read
    evt = 1'b1; status = 16'hA5C3; a0 = ack_cnt;
    xfer(32'hCC0000, 24, rx);
    chk("R8 status bits", 32'(rx[15:0]), 32'hA5C3);
    chk("R8 header pin", 32'(rx[23:16]), 32'h00);
    chk("R9 ack count", 32'(ack_cnt - a0), 32'd1);
    evt = 1'b0; status = 16'h0001; a0 = ack_cnt;
    fork
      xfer(32'hCC000000, 32, rx);
      begin wait_clk(130); status = 16'hFFFF; end
    join
    chk("R8 snapshot held", 32'(rx[23:8]), 32'h0001);
    chk("R8 zero fill", 32'(rx[7:0]), 32'h00);
    chk("R8 header pin evt=0", 32'(rx[31:24]), 32'hFF);
    chk("R9 ack count 2", 32'(ack_cnt - a0), 32'd1);
    status = 16'h8000; a0 = ack_cnt;
    xfer(32'hCC01, 16, rx);
    chk("R9 no ack for CC01", 32'(ack_cnt - a0), 32'd0);
    chk("R8 msb on CC01", 32'(rx[7]), 32'd1);
    check_regs("R11 CC01");

    // R5 frequency boundary sweeps
    for (int f = 0; f < 4096; f++) begin
      if (f <= 130 || f >= 3870) begin
        wr16({4'hA, 12'(f)});
        if (f >= 96 && f <= 3903) exp_r[2] = {4'hA, 12'(f)};
        chk($sformatf("R5 freq f=%0d", f), 32'(freq), 32'(exp_r[2]));
      end
    end

    // R6 wake-up exponent sweep
    for (int r = 0; r < 32; r++) begin
      logic [15:0] w;
      w = {3'b111, 5'(r), 8'(r * 7 + 3)};
      wr16(w);
      if (r <= 23) exp_r[8] = w;
      chk($sformatf("R6 wut r=%0d", r), 32'(wut), 32'(exp_r[8]));
    end

    // R7 soft reset over a loaded register set
    wr16(16'hE305); exp_r[8] = 16'hE305;
    xfer(32'hB2, 8, rx); exp_r[4] = 16'h00B2;
    check_regs("R7 preload");
    wr16(16'hFE00);
    set_defaults();
    check_regs("R7");

    finish_run();
  end
endmodule